// File: doc/BRIEF.md
# Protected Serial Message Framer and Checker

This block adds a protective message layer on top of a byte-wide two-wire serial link. The link itself confirms each byte only with an acknowledge bit. The transmit half builds complete messages. Each message starts with an address byte whose low bit marks an ordinary message or a critical command. Next comes a byte that holds the payload length, then the payload, and last a 16-bit CRC. A critical command is always sent as the command byte followed by its bitwise inverse. If the link reports a missing acknowledge on any byte, the framer drops the message and asks for a stop condition.

The receive half parses the same byte stream up to each stop condition, then gives one verdict per message. A message is accepted only after both CRC bytes have arrived and been checked against the address, the length and the payload. Payload bytes are held in an internal buffer and are passed out only for an accepted message. An accepted critical command is delivered as a single strobe. Bit-level start and stop signalling, bus arbitration and clock stretching belong to the link controller this block connects to.

Top module: `guarded_frame_codec`

## Requirements
- R1: A started message is sent in this order: the address byte (bits 7:1 from `tx_addr_i`, bit 0 set to 1 for a critical command and 0 otherwise), the length byte, the payload bytes, then the two CRC bytes. A length of 0 goes straight from the length byte to the CRC. Each byte is held steady on `byte_data_o` while `byte_valid_o` is high and `byte_ready_i` is low.
- R2: The CRC uses polynomial 0x1021 and starts from 0xFFFF. It is computed most significant bit first with no final inversion, over the address byte, the length byte and the payload bytes. The high CRC byte is sent first.
- R3: A critical message always carries length 2 and the payload `tx_cmd_i` followed by `~tx_cmd_i`. `tx_len_i` and the payload input are ignored for it.
- R4: If `byte_nack_i` is high during a byte handshake, the message is abandoned. On the next cycle `stop_req_o` and `tx_abort_o` each pulse for one cycle and `tx_busy_o` is low. A message that completes normally pulses `stop_req_o` alone, on the cycle after its last CRC byte is accepted.
- R5: On the cycle after a stop, `st_valid_o` pulses for one cycle for any message that contained at least one byte. `st_addr_o` gives that message's address byte, and `st_code_o` is 0 when the message is good.
- R6: The error codes are: 1 for a CRC mismatch, 2 for a bad complement, 3 for a length overrun (a byte after the second CRC byte), 4 for truncation (a stop before the second CRC byte), and 5 for a format error. When several errors apply, the order of precedence is 4, 3, 5, 1, 2.
- R7: A length of 0, or a critical message whose length is not 2, is reported as code 5.
- R8: No payload byte leaves the block before its message is judged good. For a good ordinary message, the payload comes out on `pl_out_*` starting in the same cycle as the status pulse, in the order received, with `pl_out_last_o` set on the final byte. `rx_ready_o` stays low while the payload is draining. A rejected message emits no payload.
- R9: A good critical message pulses `cmd_valid_o` in the same cycle as its status, with `cmd_o` holding the first payload byte. A critical message whose second byte is not the exact inverse of the first is rejected with code 2 and produces no command strobe.
- R10: A stop that comes when no byte has arrived since the last verdict gives no status. While `rx_stop_i` is high, `rx_ready_o` is low, so a byte offered in the same cycle stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_start_i | input | 1 | Start a message (sampled while idle) |
| tx_addr_i | input | 7 | Address, bits 7:1 of the address byte |
| tx_len_i | input | 8 | Payload length for an ordinary message |
| tx_crit_i | input | 1 | Send a critical command instead |
| tx_cmd_i | input | 8 | Critical command byte |
| pl_valid_i | input | 1 | Transmit payload byte valid |
| pl_data_i | input | 8 | Transmit payload byte |
| pl_ready_o | output | 1 | Transmit payload byte taken |
| byte_valid_o | output | 1 | Byte offered to the link |
| byte_data_o | output | 8 | Byte to the link |
| byte_ready_i | input | 1 | Link takes the byte |
| byte_nack_i | input | 1 | Byte was not acknowledged (valid during handshake) |
| stop_req_o | output | 1 | Request a stop condition (pulse) |
| tx_abort_o | output | 1 | Message abandoned on a missing acknowledge (pulse) |
| tx_busy_o | output | 1 | Framer is sending a message |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_stop_i | input | 1 | Stop condition seen on the link |
| rx_ready_o | output | 1 | Checker takes the received byte |
| st_valid_o | output | 1 | Verdict pulse |
| st_code_o | output | 3 | Verdict code |
| st_addr_o | output | 8 | Address byte of the judged message |
| cmd_valid_o | output | 1 | Accepted critical command strobe |
| cmd_o | output | 8 | Accepted critical command |
| pl_out_valid_o | output | 1 | Accepted payload byte valid |
| pl_out_data_o | output | 8 | Accepted payload byte |
| pl_out_last_o | output | 1 | Final payload byte of the message |
| pl_out_ready_i | input | 1 | Consumer takes the payload byte |

## Verification
Transmit bytes are combinational from the framer state, so the bench drives `byte_ready_i` and `byte_nack_i` half a cycle ahead of the edge. It checks `byte_data_o` just before that edge, and checks the stop and abort pulses half a cycle after the edge that follows the last handshake. A verdict and a command strobe are registered once, so they are checked half a cycle after the edge that samples `rx_stop_i`. Payload draining starts at that same point and is checked one handshake at a time, with the consumer stalled at random. For every stimulus the expected bytes, CRC, verdict code and payload are rebuilt by bench functions.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CRC_W   = 16;
  localparam int unsigned CODE_W  = 3;
  localparam logic [BYTE_W-1:0] CMD_LEN  = 8'd2;
  localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF;

  typedef enum logic [CODE_W-1:0] {
    ERR_NONE    = 3'd0,
    ERR_CRC     = 3'd1,
    ERR_COMPL   = 3'd2,
    ERR_OVERRUN = 3'd3,
    ERR_TRUNC   = 3'd4,
    ERR_FORMAT  = 3'd5
  } err_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {b, {(CRC_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/frame_tx.sv
module frame_tx
  import frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-2:0] addr_i,
  input  logic [BYTE_W-1:0] len_i,
  input  logic              crit_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic              pl_valid_i,
  input  logic [BYTE_W-1:0] pl_data_i,
  output logic              pl_ready_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  input  logic              byte_ready_i,
  input  logic              byte_nack_i,
  output logic              stop_req_o,
  output logic              abort_o,
  output logic              busy_o
);
  typedef enum logic [2:0] {T_IDLE, T_ADDR, T_CNT, T_PAY, T_CHI, T_CLO} tx_st_e;

  tx_st_e            st_q;
  logic [BYTE_W-1:0] addr_q, len_q, cmd_q, idx_q;
  logic              crit_q, stop_q, abort_q;
  logic [CRC_W-1:0]  crc_q;
  logic              hs;

  always_comb begin
    byte_valid_o = 1'b0;
    byte_data_o  = '0;
    case (st_q)
      T_ADDR: begin byte_valid_o = 1'b1; byte_data_o = addr_q; end
      T_CNT:  begin byte_valid_o = 1'b1; byte_data_o = len_q;  end
      T_PAY: begin
        if (crit_q) begin
          byte_valid_o = 1'b1;
          byte_data_o  = (idx_q == '0) ? cmd_q : ~cmd_q;
        end else begin
          byte_valid_o = pl_valid_i;
          byte_data_o  = pl_data_i;
        end
      end
      T_CHI:  begin byte_valid_o = 1'b1; byte_data_o = crc_q[CRC_W-1:BYTE_W]; end
      T_CLO:  begin byte_valid_o = 1'b1; byte_data_o = crc_q[BYTE_W-1:0];     end
      default: ;
    endcase
  end

  assign hs         = byte_valid_o && byte_ready_i;
  assign pl_ready_o = (st_q == T_PAY) && !crit_q && byte_ready_i;
  assign stop_req_o = stop_q;
  assign abort_o    = abort_q;
  assign busy_o     = (st_q != T_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
      idx_q   <= '0;
      crit_q  <= 1'b0;
      crc_q   <= CRC_INIT;
      stop_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      stop_q  <= 1'b0;
      abort_q <= 1'b0;
      if (st_q == T_IDLE) begin
        if (start_i) begin
          addr_q <= {addr_i, crit_i};
          len_q  <= crit_i ? CMD_LEN : len_i;
          cmd_q  <= cmd_i;
          crit_q <= crit_i;
          crc_q  <= CRC_INIT;
          idx_q  <= '0;
          st_q   <= T_ADDR;
        end
      end else if (hs) begin
        if (byte_nack_i) begin
          st_q    <= T_IDLE;
          stop_q  <= 1'b1;
          abort_q <= 1'b1;
        end else begin
          if (st_q == T_ADDR || st_q == T_CNT || st_q == T_PAY)
            crc_q <= crc_step(crc_q, byte_data_o);
          case (st_q)
            T_ADDR: st_q <= T_CNT;
            T_CNT:  st_q <= (len_q == '0) ? T_CHI : T_PAY;
            T_PAY: begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == len_q - 1'b1) st_q <= T_CHI;
            end
            T_CHI:  st_q <= T_CLO;
            T_CLO: begin
              st_q   <= T_IDLE;
              stop_q <= 1'b1;
            end
            default: st_q <= T_IDLE;
          endcase
        end
      end
    end
  end

  p_nack_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && byte_ready_i && byte_nack_i) |=> (stop_req_o && abort_o && !busy_o));

  p_stop_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_o |=> !stop_req_o);

  p_hold_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && st_q != T_PAY) |=> (byte_valid_o && $stable(byte_data_o)));
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_stop_i,
  output logic              rx_ready_o,
  output logic              st_valid_o,
  output logic [CODE_W-1:0] st_code_o,
  output logic [BYTE_W-1:0] st_addr_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] rd_idx_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  typedef enum logic [2:0] {R_ADDR, R_CNT, R_PAY, R_CHI, R_CLO, R_TAIL, R_DRAIN} rx_st_e;

  rx_st_e            st_q;
  logic [BYTE_W-1:0] addr_q, cnt_q, idx_q, b0_q, hi_q, lo_q;
  logic [CRC_W-1:0]  crc_q;
  logic              comp_ok_q, over_q, st_valid_q, cmd_valid_q;
  err_e              code_q, verdict;
  logic              crit, fmt_bad, crc_ok, take;

  assign rx_ready_o = (st_q != R_DRAIN) && !rx_stop_i;
  assign take       = rx_valid_i && rx_ready_o;
  assign crit       = addr_q[0];
  assign fmt_bad    = (cnt_q == '0) || (crit && cnt_q != CMD_LEN);
  assign crc_ok     = ({hi_q, lo_q} == crc_q);

  always_comb begin
    if (st_q != R_TAIL)           verdict = ERR_TRUNC;
    else if (over_q)              verdict = ERR_OVERRUN;
    else if (fmt_bad)             verdict = ERR_FORMAT;
    else if (!crc_ok)             verdict = ERR_CRC;
    else if (crit && !comp_ok_q)  verdict = ERR_COMPL;
    else                          verdict = ERR_NONE;
  end

  assign wr_en_o     = take && (st_q == R_PAY);
  assign wr_idx_o    = idx_q;
  assign wr_data_o   = rx_data_i;
  assign rd_idx_o    = idx_q;
  assign out_valid_o = (st_q == R_DRAIN);
  assign out_last_o  = (idx_q == cnt_q - 1'b1);
  assign st_valid_o  = st_valid_q;
  assign st_code_o   = code_q;
  assign st_addr_o   = addr_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = b0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= R_ADDR;
      addr_q      <= '0;
      cnt_q       <= '0;
      idx_q       <= '0;
      b0_q        <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      crc_q       <= CRC_INIT;
      comp_ok_q   <= 1'b0;
      over_q      <= 1'b0;
      st_valid_q  <= 1'b0;
      cmd_valid_q <= 1'b0;
      code_q      <= ERR_NONE;
    end else begin
      st_valid_q  <= 1'b0;
      cmd_valid_q <= 1'b0;
      if (st_q == R_DRAIN) begin
        if (out_ready_i) begin
          idx_q <= idx_q + 1'b1;
          if (out_last_o) st_q <= R_ADDR;
        end
      end else if (rx_stop_i) begin
        if (st_q != R_ADDR) begin
          st_valid_q <= 1'b1;
          code_q     <= verdict;
          over_q     <= 1'b0;
          idx_q      <= '0;
          if (verdict == ERR_NONE && !crit) begin
            st_q <= R_DRAIN;
          end else begin
            st_q        <= R_ADDR;
            cmd_valid_q <= (verdict == ERR_NONE);
          end
        end
      end else if (take) begin
        case (st_q)
          R_ADDR: begin
            addr_q <= rx_data_i;
            crc_q  <= crc_step(CRC_INIT, rx_data_i);
            st_q   <= R_CNT;
          end
          R_CNT: begin
            cnt_q     <= rx_data_i;
            crc_q     <= crc_step(crc_q, rx_data_i);
            idx_q     <= '0;
            comp_ok_q <= 1'b0;
            st_q      <= (rx_data_i == '0) ? R_CHI : R_PAY;
          end
          R_PAY: begin
            crc_q <= crc_step(crc_q, rx_data_i);
            idx_q <= idx_q + 1'b1;
            if (idx_q == '0) b0_q <= rx_data_i;
            if (idx_q == 8'd1) comp_ok_q <= (rx_data_i == ~b0_q);
            if (idx_q == cnt_q - 1'b1) st_q <= R_CHI;
          end
          R_CHI:  begin hi_q <= rx_data_i; st_q <= R_CLO; end
          R_CLO:  begin lo_q <= rx_data_i; st_q <= R_TAIL; end
          R_TAIL: over_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  p_cmd_needs_good_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (st_valid_o && st_code_o == ERR_NONE));

  p_drain_after_good_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (st_valid_o && st_code_o == ERR_NONE));

  p_stall_in_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !rx_ready_o);

  p_single_verdict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_o |=> !st_valid_o);
endmodule

// File: rtl/frame_buf.sv
module frame_buf #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/guarded_frame_codec.sv
module guarded_frame_codec
  import frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_start_i,
  input  logic [BYTE_W-2:0] tx_addr_i,
  input  logic [BYTE_W-1:0] tx_len_i,
  input  logic              tx_crit_i,
  input  logic [BYTE_W-1:0] tx_cmd_i,
  input  logic              pl_valid_i,
  input  logic [BYTE_W-1:0] pl_data_i,
  output logic              pl_ready_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  input  logic              byte_ready_i,
  input  logic              byte_nack_i,
  output logic              stop_req_o,
  output logic              tx_abort_o,
  output logic              tx_busy_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_stop_i,
  output logic              rx_ready_o,
  output logic              st_valid_o,
  output logic [CODE_W-1:0] st_code_o,
  output logic [BYTE_W-1:0] st_addr_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              pl_out_valid_o,
  output logic [BYTE_W-1:0] pl_out_data_o,
  output logic              pl_out_last_o,
  input  logic              pl_out_ready_i
);
  localparam int unsigned BUF_DEPTH = 1 << BYTE_W;

  logic              wr_en;
  logic [BYTE_W-1:0] wr_idx, wr_data, rd_idx;

  frame_tx u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (tx_start_i),
    .addr_i       (tx_addr_i),
    .len_i        (tx_len_i),
    .crit_i       (tx_crit_i),
    .cmd_i        (tx_cmd_i),
    .pl_valid_i   (pl_valid_i),
    .pl_data_i    (pl_data_i),
    .pl_ready_o   (pl_ready_o),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .byte_ready_i (byte_ready_i),
    .byte_nack_i  (byte_nack_i),
    .stop_req_o   (stop_req_o),
    .abort_o      (tx_abort_o),
    .busy_o       (tx_busy_o)
  );

  frame_rx u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .rx_stop_i   (rx_stop_i),
    .rx_ready_o  (rx_ready_o),
    .st_valid_o  (st_valid_o),
    .st_code_o   (st_code_o),
    .st_addr_o   (st_addr_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .rd_idx_o    (rd_idx),
    .out_valid_o (pl_out_valid_o),
    .out_last_o  (pl_out_last_o),
    .out_ready_i (pl_out_ready_i)
  );

  frame_buf #(.W(BYTE_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pl_out_data_o)
  );
endmodule

// File: tb/guarded_frame_codec_bench.sv
`timescale 1ns/1ps
module guarded_frame_codec_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       tx_start_i = 0, tx_crit_i = 0, pl_valid_i = 0, byte_ready_i = 0, byte_nack_i = 0;
  logic [6:0] tx_addr_i = 0;
  logic [7:0] tx_len_i = 0, tx_cmd_i = 0, pl_data_i = 0, rx_data_i = 0;
  logic       rx_valid_i = 0, rx_stop_i = 0, pl_out_ready_i = 0;
  logic       pl_ready_o, byte_valid_o, stop_req_o, tx_abort_o, tx_busy_o, rx_ready_o;
  logic       st_valid_o, cmd_valid_o, pl_out_valid_o, pl_out_last_o;
  logic [7:0] byte_data_o, st_addr_o, cmd_o, pl_out_data_o;
  logic [2:0] st_code_o;

  guarded_frame_codec u_guarded_frame_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_start_i, .tx_addr_i, .tx_len_i, .tx_crit_i, .tx_cmd_i,
    .pl_valid_i, .pl_data_i, .pl_ready_o,
    .byte_valid_o, .byte_data_o, .byte_ready_i, .byte_nack_i,
    .stop_req_o, .tx_abort_o, .tx_busy_o,
    .rx_valid_i, .rx_data_i, .rx_stop_i, .rx_ready_o,
    .st_valid_o, .st_code_o, .st_addr_o, .cmd_valid_o, .cmd_o,
    .pl_out_valid_o, .pl_out_data_o, .pl_out_last_o, .pl_out_ready_i
  );

  int checks = 0, errors = 0;
  logic [7:0] frm[$], pay[$], tpay[$], texp[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic run_tx(input logic [6:0] a, input logic [7:0] len, input bit crit,
                        input logic [7:0] cmd, input int nack_at);
    logic [15:0] c;
    int got, pidx, guard;
    bit aborted;
    tpay.delete(); texp.delete();
    if (crit) begin tpay.push_back(cmd); tpay.push_back(~cmd); end
    else for (int i = 0; i < int'(len); i++) tpay.push_back(8'($urandom));
    texp.push_back({a, crit});
    texp.push_back(crit ? 8'd2 : len);
    foreach (tpay[i]) texp.push_back(tpay[i]);
    c = 16'hFFFF;
    foreach (texp[i]) c = crc_b(c, texp[i]);
    texp.push_back(c[15:8]);
    texp.push_back(c[7:0]);
    @(negedge clk);
    tx_start_i = 1; tx_addr_i = a; tx_len_i = len; tx_crit_i = crit; tx_cmd_i = cmd;
    @(posedge clk); @(negedge clk);
    tx_start_i = 0;
    got = 0; pidx = 0; guard = 0; aborted = 0;
    while (got < texp.size() && !aborted && guard < 4000) begin
      guard++;
      byte_ready_i = ($urandom_range(0, 3) != 0);
      byte_nack_i  = (got == nack_at);
      pl_valid_i   = !crit && (pidx < tpay.size());
      pl_data_i    = pl_valid_i ? tpay[pidx] : 8'h00;
      #1;
      if (byte_valid_o && byte_ready_i) begin
        // R1 order, R2 CRC bytes, R3 command pair
        chk(byte_data_o == texp[got], (got >= texp.size() - 2) ? "R2" : (crit ? "R3" : "R1"),
            "tx byte", byte_data_o, texp[got]);
        if (pl_ready_o && pl_valid_i) pidx++;
        if (byte_nack_i) aborted = 1;
        got++;
      end
      @(posedge clk); @(negedge clk);
    end
    byte_ready_i = 0; byte_nack_i = 0; pl_valid_i = 0;
    chk(guard < 4000, "R1", "tx progress", guard, 0);
    chk(stop_req_o == 1'b1, "R4", "stop request", stop_req_o, 1);
    chk(tx_abort_o == aborted, "R4", "abort flag", tx_abort_o, aborted);
    chk(tx_busy_o == 1'b0, "R4", "busy after end", tx_busy_o, 0);
  endtask

  task automatic make_frame(input logic [7:0] a, input logic [7:0] cnt,
                            input bit bad_crc, input bit extra, input bit trunc);
    logic [15:0] c;
    frm.delete();
    frm.push_back(a);
    frm.push_back(cnt);
    foreach (pay[i]) frm.push_back(pay[i]);
    c = 16'hFFFF;
    foreach (frm[i]) c = crc_b(c, frm[i]);
    if (bad_crc) c ^= 16'h0100;
    if (!trunc) begin frm.push_back(c[15:8]); frm.push_back(c[7:0]); end
    if (extra) frm.push_back(8'h5A);
  endtask

  task automatic feed_check(input int ecode, input bit ecmd, input string tag);
    int k, guard;
    foreach (frm[i]) begin
      @(negedge clk);
      rx_valid_i = 1; rx_data_i = frm[i];
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid_i = 0; rx_stop_i = 1;
    #1;
    chk(rx_ready_o == 1'b0, "R10", "ready during stop", rx_ready_o, 0);
    @(posedge clk); @(negedge clk);
    rx_stop_i = 0;
    chk(st_valid_o == 1'b1, tag, "status valid", st_valid_o, 1);
    chk(st_code_o == 3'(ecode), tag, "status code", st_code_o, ecode);
    chk(st_addr_o == frm[0], "R5", "status addr", st_addr_o, frm[0]);
    chk(cmd_valid_o == ecmd, "R9", "command strobe", cmd_valid_o, ecmd);
    if (ecmd) chk(cmd_o == pay[0], "R9", "command value", cmd_o, pay[0]);
    if (ecode == 0 && !frm[0][0]) begin
      chk(rx_ready_o == 1'b0, "R8", "stall while draining", rx_ready_o, 0);
      k = 0; guard = 0;
      while (k < pay.size() && guard < 4000) begin
        guard++;
        pl_out_ready_i = ($urandom_range(0, 2) != 0);
        #1;
        if (pl_out_valid_o && pl_out_ready_i) begin
          chk(pl_out_data_o == pay[k], "R8", "payload byte", pl_out_data_o, pay[k]);
          chk(pl_out_last_o == (k == pay.size() - 1), "R8", "last flag", pl_out_last_o, k == pay.size() - 1);
          k++;
        end
        @(posedge clk); @(negedge clk);
      end
      pl_out_ready_i = 0;
      chk(k == pay.size(), "R8", "payload count", k, pay.size());
      chk(!pl_out_valid_o && rx_ready_o, "R8", "drain finished", pl_out_valid_o, 0);
    end else begin
      chk(pl_out_valid_o == 1'b0, "R8", "no payload on reject", pl_out_valid_o, 0);
    end
  endtask

  function automatic int exp_code(input logic [7:0] a, input logic [7:0] cnt,
                                  input bit bad_crc, input bit extra, input bit trunc);
    if (trunc) return 4;
    if (extra) return 3;
    if (cnt == 0 || (a[0] && cnt != 2)) return 5;
    if (bad_crc) return 1;
    if (a[0] && pay[1] != ~pay[0]) return 2;
    return 0;
  endfunction

  task automatic run_rx(input logic [7:0] a, input logic [7:0] cnt, input bit bad_crc,
                        input bit extra, input bit trunc, input string tag);
    int ec;
    make_frame(a, cnt, bad_crc, extra, trunc);
    ec = exp_code(a, cnt, bad_crc, extra, trunc);
    feed_check(ec, (ec == 0) && a[0], tag);
  endtask

  task automatic rand_pay(input int n);
    pay.delete();
    for (int i = 0; i < n; i++) pay.push_back(8'($urandom));
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] c8;
    void'($urandom(32'h1D5C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(byte_valid_o == 0 && tx_busy_o == 0, "R1", "reset tx idle", byte_valid_o, 0);
    chk(st_valid_o == 0 && pl_out_valid_o == 0 && rx_ready_o == 1, "R5", "reset rx idle", st_valid_o, 0);

    // transmit, directed
    run_tx(7'h52, 8'd3, 0, 8'h00, -1);   // R1 R2
    run_tx(7'h18, 8'd0, 0, 8'h00, -1);   // R1 zero length
    run_tx(7'h18, 8'd9, 1, 8'h3C, -1);   // R3 length ignored
    run_tx(7'h20, 8'd5, 0, 8'h00, 2);    // R4 nack in payload
    run_tx(7'h21, 8'd0, 1, 8'h99, 4);    // R4 nack on CRC high
    run_tx(7'h22, 8'd4, 0, 8'h00, 0);    // R4 nack on address
    for (int n = 0; n < 20; n++)
      run_tx(7'($urandom), 8'($urandom_range(1, 12)), $urandom_range(0, 3) == 0, 8'($urandom), -1);

    // receive, directed
    rand_pay(4); run_rx(8'hA4, 8'd4, 0, 0, 0, "R5");
    pay = '{8'h5A, 8'hA5}; run_rx(8'h31, 8'd2, 0, 0, 0, "R9");
    pay = '{8'h11, 8'h22}; run_rx(8'h31, 8'd2, 0, 0, 0, "R9");
    rand_pay(3); run_rx(8'h40, 8'd3, 1, 0, 0, "R6");
    rand_pay(2); run_rx(8'h42, 8'd2, 0, 1, 0, "R6");
    rand_pay(5); run_rx(8'h44, 8'd5, 0, 0, 1, "R6");
    pay.delete(); run_rx(8'h46, 8'd0, 0, 0, 0, "R7");
    rand_pay(3); run_rx(8'h47, 8'd3, 0, 0, 0, "R7");
    pay.delete(); run_rx(8'h48, 8'd0, 1, 0, 0, "R6");
    rand_pay(1); run_rx(8'h4A, 8'd1, 0, 0, 0, "R8");
    pay.delete(); frm = '{8'h10}; feed_check(4, 0, "R6");

    // idle stop ignored
    @(negedge clk); rx_stop_i = 1;
    @(posedge clk); @(negedge clk); rx_stop_i = 0;
    chk(st_valid_o == 0, "R10", "idle stop no status", st_valid_o, 0);
    @(posedge clk); @(negedge clk);
    chk(st_valid_o == 0, "R10", "idle stop quiet", st_valid_o, 0);

    // receive, random
    for (int n = 0; n < 40; n++) begin
      int kind;
      kind = $urandom_range(0, 5);
      case (kind)
        0: begin rand_pay($urandom_range(1, 12)); run_rx({7'($urandom), 1'b0}, 8'(pay.size()), 0, 0, 0, "R5"); end
        1: begin c8 = 8'($urandom); pay = '{c8, ~c8}; run_rx({7'($urandom), 1'b1}, 8'd2, 0, 0, 0, "R9"); end
        2: begin rand_pay($urandom_range(1, 12)); run_rx({7'($urandom), 1'b0}, 8'(pay.size()), 1, 0, 0, "R6"); end
        3: begin c8 = 8'($urandom); pay = '{c8, ~c8 ^ 8'($urandom_range(1, 255))}; run_rx({7'($urandom), 1'b1}, 8'd2, 0, 0, 0, "R9"); end
        4: begin rand_pay($urandom_range(1, 12)); run_rx({7'($urandom), 1'b0}, 8'(pay.size()), 0, 1, 0, "R6"); end
        default: begin rand_pay($urandom_range(1, 12)); run_rx({7'($urandom), 1'b0}, 8'(pay.size()), 0, 0, 1, "R6"); end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule